// File: doc/BRIEF.md
# Discriminator Hit Timestamper

This block sits between one bank of sixteen discriminator outputs and a data formatter. Each channel arrives as several samples per system clock cycle, taken on evenly spaced clock phases. The block finds the first rising edge on each channel and encodes the earliest phase that saw the input high. It joins that phase code to a coarse cycle counter that restarts at spill start. With a 100 MHz beam-locked clock and four phases, this gives 2.5 ns resolution. Each result becomes a record of channel address plus timestamp and is queued for a consumer that uses a valid/ready handshake.

Only the high-gain discriminator bank is timestamped. The block drives the two bank-enable lines from a bank select input, and it records hits only while the high-gain bank is the one enabled. A preamp reset window does three things: it clears the discriminators through a dedicated output, it blocks capture, and it re-arms every channel. Each channel therefore gives at most one record per integration period. When hits arrive faster than the queue can absorb them, the extra records are dropped and a sticky overflow flag is raised.

Top module: `hit_stamper`

## Requirements
- R1: `disc_smp` bit `c*NPH+p` is channel c seen on phase p, with phase 0 earliest. A channel has a rising edge in a cycle when its last-phase sample of the previous cycle was low and at least one of its samples in this cycle is high.
- R2: A record's `rec_time` is the coarse count in its upper CW bits and the phase code in its lower PW bits. The phase code is the lowest phase index whose sample is high. The coarse count is 0 in the cycle after the cycle with `spill_start` high, rises by one each cycle, and wraps.
- R3: A hit captured in cycle N, with an empty queue and no other pending channel, shows `rec_valid` high with its channel and time after clock edge N+1.
- R4: Channels that fire in the same cycle are queued one per cycle in ascending channel order, and all carry the same timestamp apart from their own phase codes.
- R5: After a channel is recorded, further rising edges on it make no record until a cycle with `preamp_reset` high re-arms it.
- R6: No hit is captured in a cycle with `preamp_reset` high. `disc_clr_n` is low in the cycle after every cycle with `preamp_reset` high, and high otherwise once out of reset.
- R7: An input that stays high through the re-arm window makes no record until it falls and rises again.
- R8: The bank enables are registered from `bank_sel`: `bank_en_lo` equals NOT `bank_sel` and `bank_en_hi` equals `bank_sel`, one cycle later. Both enables and `disc_clr_n` are low in reset.
- R9: Hits are captured only while the enable of the high-gain bank (parameter HIGAIN_BANK, default lower bank) is high. A channel ignored this way stays armed.
- R10: A record pushed while the queue (DEPTH entries) is full is dropped, and so is a new hit on a channel whose earlier record is still pending. Either case sets `overflow`, which stays set until a cycle with `spill_start` high clears it. The clear takes priority.
- R11: While `rec_valid` is high and `rec_ready` is low, `rec_valid`, `rec_chan` and `rec_time` hold their values. Records leave in the order they were queued.
- R12: In reset, `rec_valid` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beam-locked system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spill_start | input | 1 | Restarts the coarse counter and clears overflow |
| preamp_reset | input | 1 | Preamp reset window; re-arms channels and blocks capture |
| bank_sel | input | 1 | Bank to enable: 0 lower, 1 upper |
| disc_smp | input | NCH*NPH | Per-channel phase samples of the discriminator outputs |
| bank_en_lo | output | 1 | Enable for the lower discriminator bank |
| bank_en_hi | output | 1 | Enable for the upper discriminator bank |
| disc_clr_n | output | 1 | Active-low discriminator clear |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_chan | output | AW | Channel address of the record |
| rec_time | output | CW+PW | Coarse count and phase code |
| overflow | output | 1 | Sticky record-loss flag |

## Verification
Single hits are swept across every phase code, both end channels and several delays after spill start, so that an error in coarse alignment or in phase encoding shows up as a specific wrong field. Three channels fired in one cycle with different phases test the ordering and the shared coarse stamp. A channel that falls and rises again, or that is held high across the re-arm, separates true edge detection from level detection and shows whether re-arming works. A burst on all channels with the consumer stalled separates queue-full loss from pending-slot loss and checks the sticky flag and its clear. The low-gain bank selection and the reset window check that captures are blocked and that the blocked channel stays armed.

// File: rtl/hts_pkg.sv
package hts_pkg;

  // Which discriminator bank carries the high-gain channels.
  typedef enum logic {
    BANK_LO = 1'b0,
    BANK_HI = 1'b1
  } bank_e;

endpackage

// File: rtl/hts_edge_cap.sv
// One channel: rising-edge detection over phase samples, one-shot arming,
// and lowest-high-phase encoding.
module hts_edge_cap #(
  parameter int NPH = 4,
  localparam int PW = $clog2(NPH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NPH-1:0] smp,
  input  logic          rearm,
  input  logic          enable,
  output logic          hit,
  output logic [PW-1:0] code
);

  logic armed_q, armed_d;
  logic last_q, last_d;

  always_comb begin
    code = '0;
    for (int i = NPH - 1; i >= 0; i--) begin
      if (smp[i]) code = PW'(i);
    end
  end

  always_comb begin
    hit    = armed_q && enable && !rearm && !last_q && (|smp);
    last_d = smp[NPH-1];
    if (rearm)    armed_d = 1'b1;
    else if (hit) armed_d = 1'b0;
    else          armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      last_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      last_q  <= last_d;
    end
  end

endmodule

// File: rtl/hts_pend.sv
// Per-channel holding slots; lowest pending channel is forwarded each cycle.
module hts_pend #(
  parameter int NCH = 16,
  parameter int TW  = 16,
  localparam int AW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NCH-1:0] hit,
  input  logic [NCH*TW-1:0] stamp_in,
  output logic          push,
  output logic [AW-1:0] push_chan,
  output logic [TW-1:0] push_time,
  output logic          lost
);

  logic [NCH-1:0] pend_q, pend_d;
  logic [TW-1:0]  stamp_q [NCH];
  logic [TW-1:0]  stamp_d [NCH];
  logic [NCH-1:0] pick;
  logic [NCH-1:0] lost_v;

  always_comb begin
    push_chan = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_q[i]) push_chan = AW'(i);
    end
    push      = |pend_q;
    push_time = stamp_q[push_chan];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    assign pick[g]   = push && (push_chan == AW'(g));
    assign lost_v[g] = hit[g] && pend_q[g] && !pick[g];

    always_comb begin
      pend_d[g]  = pend_q[g];
      stamp_d[g] = stamp_q[g];
      if (pick[g]) pend_d[g] = 1'b0;
      if (hit[g] && (!pend_q[g] || pick[g])) begin
        pend_d[g]  = 1'b1;
        stamp_d[g] = stamp_in[g*TW +: TW];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g]  <= 1'b0;
        stamp_q[g] <= '0;
      end else begin
        pend_q[g]  <= pend_d[g];
        stamp_q[g] <= stamp_d[g];
      end
    end
  end

  assign lost = |lost_v;

endmodule

// File: rtl/hts_fifo.sv
// Show-ahead record queue; DEPTH must be a power of two.
module hts_fifo #(
  parameter int DW    = 20,
  parameter int DEPTH = 8,
  localparam int PTW  = $clog2(DEPTH),
  localparam int CTW  = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic          valid,
  output logic          full
);

  logic [DW-1:0]  mem [DEPTH];
  logic [PTW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CTW-1:0] cnt_q, cnt_d;
  logic           do_wr, do_rd;

  assign full  = (cnt_q == CTW'(DEPTH));
  assign valid = (cnt_q != '0);
  assign rdata = mem[rp_q];
  assign do_wr = wr && !full;
  assign do_rd = rd && valid;

  always_comb begin
    wp_d  = do_wr ? wp_q + PTW'(1) : wp_q;
    rp_d  = do_rd ? rp_q + PTW'(1) : rp_q;
    cnt_d = cnt_q;
    if (do_wr && !do_rd)      cnt_d = cnt_q + CTW'(1);
    else if (do_rd && !do_wr) cnt_d = cnt_q - CTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wdata;
  end

endmodule

// File: rtl/hit_stamper.sv
module hit_stamper #(
  parameter int NCH = 16,
  parameter int NPH = 4,
  parameter int CW  = 14,
  parameter int DEPTH = 8,
  parameter hts_pkg::bank_e HIGAIN_BANK = hts_pkg::BANK_LO,
  localparam int AW = $clog2(NCH),
  localparam int PW = $clog2(NPH),
  localparam int TW = CW + PW,
  localparam int RW = AW + TW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spill_start,
  input  logic              preamp_reset,
  input  logic              bank_sel,
  input  logic [NCH*NPH-1:0] disc_smp,
  output logic              bank_en_lo,
  output logic              bank_en_hi,
  output logic              disc_clr_n,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [AW-1:0]     rec_chan,
  output logic [TW-1:0]     rec_time,
  output logic              overflow
);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // Bank enables and discriminator clear.
  logic en_lo_q, en_hi_q, clr_n_q;
  logic en_lo_d, en_hi_d, clr_n_d;
  logic active;

  always_comb begin
    en_lo_d = !bank_sel;
    en_hi_d = bank_sel;
    clr_n_d = !preamp_reset;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      en_lo_q <= 1'b0;
      en_hi_q <= 1'b0;
      clr_n_q <= 1'b0;
    end else begin
      en_lo_q <= en_lo_d;
      en_hi_q <= en_hi_d;
      clr_n_q <= clr_n_d;
    end
  end

  assign bank_en_lo = en_lo_q;
  assign bank_en_hi = en_hi_q;
  assign disc_clr_n = clr_n_q;

  if (HIGAIN_BANK == hts_pkg::BANK_HI) begin : g_act_hi
    assign active = en_hi_q;
  end else begin : g_act_lo
    assign active = en_lo_q;
  end

  // Coarse counter.
  logic [CW-1:0] coarse_q, coarse_d;
  always_comb begin
    coarse_d = spill_start ? '0 : coarse_q + CW'(1);
  end
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) coarse_q <= '0;
    else        coarse_q <= coarse_d;
  end

  // Per-channel edge capture.
  logic [NCH-1:0]    cap_hit;
  logic [NCH*TW-1:0] cap_stamp;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [PW-1:0] code;
    hts_edge_cap #(.NPH(NPH)) u_cap (
      .clk    (clk),
      .rst_n  (rst_q),
      .smp    (disc_smp[c*NPH +: NPH]),
      .rearm  (preamp_reset),
      .enable (active),
      .hit    (cap_hit[c]),
      .code   (code)
    );
    assign cap_stamp[c*TW +: TW] = {coarse_q, code};
  end

  // Pending slots and ordering.
  logic          push, lost;
  logic [AW-1:0] push_chan;
  logic [TW-1:0] push_time;

  hts_pend #(.NCH(NCH), .TW(TW)) u_pend (
    .clk       (clk),
    .rst_n     (rst_q),
    .hit       (cap_hit),
    .stamp_in  (cap_stamp),
    .push      (push),
    .push_chan (push_chan),
    .push_time (push_time),
    .lost      (lost)
  );

  // Output queue.
  logic          fifo_full;
  logic [RW-1:0] head;

  hts_fifo #(.DW(RW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_q),
    .wr    (push),
    .wdata ({push_chan, push_time}),
    .rd    (rec_ready),
    .rdata (head),
    .valid (rec_valid),
    .full  (fifo_full)
  );

  assign rec_chan = head[RW-1 -: AW];
  assign rec_time = head[TW-1:0];

  // Sticky loss flag; spill start wins.
  logic ovf_q, ovf_d;
  always_comb begin
    if (spill_start)                     ovf_d = 1'b0;
    else if ((push && fifo_full) || lost) ovf_d = 1'b1;
    else                                 ovf_d = ovf_q;
  end
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end
  assign overflow = ovf_q;

endmodule

// File: rtl/hts_chk.sv
module hts_chk #(
  parameter int NCH = 16,
  parameter int AW  = 4,
  parameter int TW  = 16
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          spill_start,
  input logic          preamp_reset,
  input logic          bank_sel,
  input logic          bank_en_lo,
  input logic          bank_en_hi,
  input logic          disc_clr_n,
  input logic          rec_valid,
  input logic          rec_ready,
  input logic [AW-1:0] rec_chan,
  input logic [TW-1:0] rec_time,
  input logic          overflow,
  input logic          push,
  input logic          fifo_full,
  input logic          active,
  input logic [NCH-1:0] cap_hit
);

  p_clear_out_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    preamp_reset |=> !disc_clr_n);

  p_no_cap_window_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    preamp_reset |-> (cap_hit == '0));

  p_no_cap_lowgain_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !active |-> (cap_hit == '0));

  p_bank_excl_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !(bank_en_lo && bank_en_hi));

  p_bank_follow_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    bank_sel |=> (bank_en_hi && !bank_en_lo));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_chan) && $stable(rec_time)));

  p_ovf_set_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (push && fifo_full && !spill_start) |=> overflow);

  p_ovf_clear_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    spill_start |=> !overflow);

  p_ovf_keep_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (overflow && !spill_start) |=> overflow);

endmodule

bind hit_stamper hts_chk #(.NCH(NCH), .AW(AW), .TW(TW)) u_chk (
  .clk          (clk),
  .rst_ni       (rst_q),
  .spill_start  (spill_start),
  .preamp_reset (preamp_reset),
  .bank_sel     (bank_sel),
  .bank_en_lo   (bank_en_lo),
  .bank_en_hi   (bank_en_hi),
  .disc_clr_n   (disc_clr_n),
  .rec_valid    (rec_valid),
  .rec_ready    (rec_ready),
  .rec_chan     (rec_chan),
  .rec_time     (rec_time),
  .overflow     (overflow),
  .push         (push),
  .fifo_full    (fifo_full),
  .active       (active),
  .cap_hit      (cap_hit)
);

// File: tb/sim_hit_stamper.sv
`timescale 1ns/1ps
module sim_hit_stamper;

  localparam int NCH = 16, NPH = 4, CW = 14, DEPTH = 8;
  localparam int TW = CW + 2;

  logic clk = 1'b0;
  logic rst_n, spill_start, preamp_reset, bank_sel, rec_ready;
  logic [NCH*NPH-1:0] smp;
  logic bank_en_lo, bank_en_hi, disc_clr_n, rec_valid, overflow;
  logic [3:0] rec_chan;
  logic [TW-1:0] rec_time;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hit_stamper #(.NCH(NCH), .NPH(NPH), .CW(CW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .spill_start(spill_start), .preamp_reset(preamp_reset),
    .bank_sel(bank_sel), .disc_smp(smp), .bank_en_lo(bank_en_lo), .bank_en_hi(bank_en_hi),
    .disc_clr_n(disc_clr_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_chan(rec_chan), .rec_time(rec_time), .overflow(overflow)
  );

  // Vector: {chan[3:0], phase[1:0], delay[5:0]}
  localparam logic [11:0] VEC [8] = '{
    {4'd0,  2'd0, 6'd0},  {4'd15, 2'd3, 6'd1},
    {4'd7,  2'd1, 6'd5},  {4'd8,  2'd2, 6'd2},
    {4'd3,  2'd3, 6'd0},  {4'd12, 2'd0, 6'd17},
    {4'd5,  2'd2, 6'd40}, {4'd10, 2'd1, 6'd9}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [NCH*NPH-1:0] pat(input int ch, input int ph);
    logic [NCH*NPH-1:0] v = '0;
    for (int i = 0; i < NPH; i++) if (i >= ph) v[ch*NPH + i] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] stamp(input int coarse, input int ph);
    return 32'((coarse << 2) | ph);
  endfunction

  // Leaves the bench at the start of the cycle where the coarse count is 0.
  task automatic rearm_spill();
    preamp_reset = 1'b1;
    tick();
    preamp_reset = 1'b0;
    spill_start = 1'b1;
    tick();
    spill_start = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; spill_start = 1'b0; preamp_reset = 1'b0;
    bank_sel = 1'b0; rec_ready = 1'b1; smp = '0;
    repeat (3) tick();
    // R12 / R8 reset state
    chk("R12 valid in reset", 32'(rec_valid), 0);
    chk("R12 overflow in reset", 32'(overflow), 0);
    chk("R8 enables in reset", 32'({bank_en_lo, bank_en_hi, disc_clr_n}), 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R8 lower bank enabled", 32'({bank_en_lo, bank_en_hi}), 32'b10);
    chk("R6 clear released", 32'(disc_clr_n), 1);

    // Table walk: single hits (R1 R2 R3)
    foreach (VEC[v]) begin
      int ch = int'(VEC[v][11:8]);
      int ph = int'(VEC[v][7:6]);
      int dl = int'(VEC[v][5:0]);
      rearm_spill();
      repeat (dl) tick();
      smp = pat(ch, ph);
      tick(); tick();
      chk("R3 record valid", 32'(rec_valid), 1);
      chk("R1 channel", 32'(rec_chan), 32'(ch));
      chk("R2 timestamp", 32'(rec_time), stamp(dl, ph));
      tick();
      chk("R11 popped", 32'(rec_valid), 0);
      smp = '0;
      tick();
    end

    // R4: three channels in one cycle
    rearm_spill();
    repeat (3) tick();
    smp = pat(9, 1) | pat(3, 2) | pat(12, 0);
    tick(); tick();
    chk("R4 first chan", 32'(rec_chan), 3);
    chk("R4 first time", 32'(rec_time), stamp(3, 2));
    tick();
    chk("R4 second chan", 32'(rec_chan), 9);
    chk("R4 second time", 32'(rec_time), stamp(3, 1));
    tick();
    chk("R4 third chan", 32'(rec_chan), 12);
    chk("R4 third time", 32'(rec_time), stamp(3, 0));
    tick();
    chk("R4 drained", 32'(rec_valid), 0);

    // R5: second edge without re-arm is ignored
    smp = '0;
    tick();
    smp = pat(9, 0);
    repeat (4) tick();
    chk("R5 no second record", 32'(rec_valid), 0);
    smp = '0;
    tick();
    rearm_spill();
    smp = pat(9, 0);
    tick(); tick();
    chk("R5 re-armed record", 32'(rec_valid), 1);
    chk("R5 re-armed chan", 32'(rec_chan), 9);
    chk("R5 re-armed time", 32'(rec_time), stamp(0, 0));
    tick();
    smp = '0;
    tick();

    // R7: input held high across re-arm
    smp = pat(6, 0);
    tick(); tick();
    chk("R7 initial record", 32'(rec_chan), 6);
    tick();
    rearm_spill();
    repeat (4) tick();
    chk("R7 held high no record", 32'(rec_valid), 0);
    smp = '0;
    tick();
    smp = pat(6, 2);
    tick(); tick();
    chk("R7 fresh edge valid", 32'(rec_valid), 1);
    chk("R7 fresh edge time", 32'(rec_time), stamp(5, 2));
    tick();
    smp = '0;
    tick();

    // R6: capture blocked inside the preamp reset window
    preamp_reset = 1'b1;
    tick();
    smp = pat(2, 0);
    tick();
    chk("R6 clear asserted", 32'(disc_clr_n), 0);
    tick();
    preamp_reset = 1'b0;
    tick(); tick();
    chk("R6 no capture in window", 32'(rec_valid), 0);
    chk("R6 clear released", 32'(disc_clr_n), 1);
    smp = '0;
    tick();
    smp = pat(2, 0);
    tick(); tick();
    chk("R6 re-armed by window", 32'(rec_chan), 2);
    tick();
    smp = '0;
    tick();

    // R9: low-gain bank selected, hits ignored
    bank_sel = 1'b1;
    tick(); tick();
    chk("R8 upper bank enabled", 32'({bank_en_lo, bank_en_hi}), 32'b01);
    rearm_spill();
    smp = pat(4, 0);
    repeat (4) tick();
    chk("R9 low-gain ignored", 32'(rec_valid), 0);
    smp = '0;
    bank_sel = 1'b0;
    tick(); tick();
    chk("R8 lower bank again", 32'(bank_en_lo), 1);
    smp = pat(4, 1);
    tick(); tick();
    chk("R9 still armed chan", 32'(rec_chan), 4);
    chk("R9 still armed valid", 32'(rec_valid), 1);
    tick();
    smp = '0;
    tick();

    // R10 / R11: burst on all channels with consumer stalled
    rearm_spill();
    rec_ready = 1'b0;
    smp = '1;
    tick();
    smp = '0;
    repeat (20) tick();
    chk("R10 overflow set", 32'(overflow), 1);
    chk("R11 head held chan", 32'(rec_chan), 0);
    tick();
    chk("R11 head still held", 32'({rec_valid, rec_chan}), 32'h10);
    rec_ready = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      chk("R10 kept records in order", 32'(rec_chan), 32'(i));
      tick();
    end
    chk("R10 dropped rest", 32'(rec_valid), 0);
    chk("R10 flag sticky", 32'(overflow), 1);
    spill_start = 1'b1;
    tick();
    spill_start = 1'b0;
    tick();
    chk("R10 cleared by spill start", 32'(overflow), 0);

    finish_run();
  end

endmodule